// File: doc/BRIEF.md
# Key Matrix Row Scanner

This block connects a five-row key matrix to a 16-bit register bus. Software picks which matrix columns are driven by writing a column register, and the block reports which rows see a pressed key in a driven column. Both the columns and the reported rows are active-low. The row result is held in a five-bit latch. That latch reads all ones when no row is active.

The per-key state comes in as five row vectors of eight column bits each. This input is asynchronous, so it passes through a synchronizer before it is evaluated. A clock-enable input decides how the latch is refreshed. While the enable is high, the latch follows the matrix on every cycle. While it is low, the latch is re-evaluated only when software writes the column register or the mask register. A key interrupt output is raised when some row is active, the mask is clear and the enable is high.

Top module: `keyscan_row_latch`

## Requirements
- R1: After reset the row latch reads 0x1F, the column register reads 0xFF, the mask reads 0, the interrupt status reads 0 and `key_irq` is low.
- R2: The register map is as follows. Offset 0x10 is the row latch in bits 4:0. Offset 0x14 is the column register in bits 7:0. Offset 0x20 is the interrupt status in bit 0. Offset 0x28 is the mask in bit 0. All unused bits, and every other offset, read 0.
- R3: Input bit `keys_in[r*8+c]` = 1 means the key at row r, column c is pressed. Row latch bit r reads 0 exactly when some pressed key in row r lies in a column c whose column register bit c is 0. Column bits that are 1 select nothing.
- R4: Writes to offsets 0x10, 0x20 and to unmapped offsets change no register.
- R5: The mask register keeps only data bit 0. Writing 0xFFFF to it reads back 1.
- R6: The interrupt status reads 1 exactly when the row latch differs from 0x1F and the mask is 0.
- R7: `key_irq` equals the interrupt status ANDed with `clk_en`.
- R8: While `clk_en` is high, the latch is refreshed every cycle. A change on `keys_in` reaches the latch on the third rising edge after it is applied.
- R9: While `clk_en` is low, a change on `keys_in` leaves the latch unchanged. A write to the column register or to the mask re-evaluates the latch, using the written column value, on that write's clock edge.
- R10: When `clk_en` rises, the latch is re-evaluated on the first edge with the enable high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_en | input | 1 | Scan clock enable, synchronous level |
| keys_in | input | 40 | Key states, row r column c at bit r*8+c, 1 = pressed |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| addr | input | 8 | Register byte offset |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr`, combinational |
| key_irq | output | 1 | Key interrupt request |

## Verification
The assertions make two assumptions about the inputs. First, `clk_en`, `wr_en`, `addr` and `wdata` are synchronous to `clk` and are stable around each rising edge. Second, `keys_in` may move at any time, because the assertions look only at its synchronized copy through the latch. The bench honours this by changing every input on the falling edge. It changes key patterns only after it has waited out the synchronizer delay, except in the test that measures that delay.

// File: rtl/kms_pkg.sv
package kms_pkg;
   localparam logic [7:0] OFS_ROWS = 8'h10;
   localparam logic [7:0] OFS_COLS = 8'h14;
   localparam logic [7:0] OFS_STAT = 8'h20;
   localparam logic [7:0] OFS_MASK = 8'h28;
endpackage

// File: rtl/kms_sync.sv
module kms_sync #(
   parameter int W      = 40,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   initial begin
      assert (STAGES >= 0 && STAGES <= 4) else $error("kms_sync: STAGES out of range");
   end

   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [W-1:0] stage_q [STAGES];
         for (genvar s = 0; s < STAGES; s++) begin : g_st
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[s] <= '0;
               else if (s == 0) stage_q[s] <= d;
               else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
         end
         assign q = stage_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/kms_row_eval.sv
module kms_row_eval #(
   parameter int ROWS = 5,
   parameter int COLS = 8
) (
   input  logic [ROWS*COLS-1:0] keys,
   input  logic [COLS-1:0]      col_drive_n,
   output logic [ROWS-1:0]      rows_n
);
   generate
      for (genvar r = 0; r < ROWS; r++) begin : g_row
         assign rows_n[r] = ~|(keys[r*COLS +: COLS] & ~col_drive_n);
      end
   endgenerate
endmodule

// File: rtl/keyscan_row_latch.sv
module keyscan_row_latch #(
   parameter int ROWS        = 5,
   parameter int COLS        = 8,
   parameter int ADDR_W      = 8,
   parameter int DATA_W      = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clk_en,
   input  logic [ROWS*COLS-1:0] keys_in,
   input  logic                 wr_en,
   input  logic [ADDR_W-1:0]    addr,
   input  logic [DATA_W-1:0]    wdata,
   output logic [DATA_W-1:0]    rdata,
   output logic                 key_irq
);
   import kms_pkg::*;

   localparam int              NKEY = ROWS * COLS;
   localparam logic [ROWS-1:0] IDLE = {ROWS{1'b1}};

   initial begin
      assert (ROWS <= DATA_W && COLS <= DATA_W) else $error("keyscan: field wider than bus");
      assert (ADDR_W >= 6) else $error("keyscan: address too narrow for map");
   end

   logic [NKEY-1:0] keys_s;
   logic [COLS-1:0] col_q, col_next;
   logic            mask_q;
   logic [ROWS-1:0] row_q, row_d;
   logic            col_wr, mask_wr, refresh, stat;

   kms_sync #(.W(NKEY), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(keys_in), .q(keys_s));

   assign col_wr   = wr_en && (addr == ADDR_W'(OFS_COLS));
   assign mask_wr  = wr_en && (addr == ADDR_W'(OFS_MASK));
   assign col_next = col_wr ? wdata[COLS-1:0] : col_q;
   assign refresh  = clk_en || col_wr || mask_wr;

   kms_row_eval #(.ROWS(ROWS), .COLS(COLS)) u_eval (
      .keys(keys_s), .col_drive_n(col_next), .rows_n(row_d));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         col_q  <= '1;
         mask_q <= 1'b0;
         row_q  <= IDLE;
      end else begin
         if (col_wr)  col_q  <= wdata[COLS-1:0];
         if (mask_wr) mask_q <= wdata[0];
         if (refresh) row_q  <= row_d;
      end
   end

   assign stat    = (row_q != IDLE) && !mask_q;
   assign key_irq = stat && clk_en;

   always_comb begin
      rdata = '0;
      if (addr == ADDR_W'(OFS_ROWS))      rdata[ROWS-1:0] = row_q;
      else if (addr == ADDR_W'(OFS_COLS)) rdata[COLS-1:0] = col_q;
      else if (addr == ADDR_W'(OFS_STAT)) rdata[0]        = stat;
      else if (addr == ADDR_W'(OFS_MASK)) rdata[0]        = mask_q;
   end

   // R7
   irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      key_irq |-> (clk_en && !mask_q));
   // R6
   irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (row_q == IDLE) |-> !key_irq);
   // R9
   latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clk_en && !col_wr && !mask_wr) |=> $stable(row_q));
   // R3
   no_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_en && (&col_q) && !col_wr) |=> (row_q == IDLE));
endmodule

// File: tb/keyscan_row_latch_test.sv
module keyscan_row_latch_test;
   logic        clk = 0;
   logic        rst_n = 0;
   logic        clk_en = 0;
   logic [39:0] keys_in = '0;
   logic        wr_en = 0;
   logic [7:0]  addr = '0;
   logic [15:0] wdata = '0;
   logic [15:0] rdata;
   logic        key_irq;
   int total = 0, bad = 0;
   bit done = 0;

   keyscan_row_latch uut (.clk(clk), .rst_n(rst_n), .clk_en(clk_en), .keys_in(keys_in),
      .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .key_irq(key_irq));

   always #5 clk = ~clk;

   function automatic logic [4:0] exp_rows(logic [39:0] k, logic [7:0] col);
      logic [4:0] r5 = 5'h1F;
      for (int r = 0; r < 5; r++)
         for (int c = 0; c < 8; c++)
            if (k[r*8+c] && !col[c]) r5[r] = 1'b0;
      return r5;
   endfunction

   task automatic chk(string req, logic [15:0] got, logic [15:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got=%h exp=%h", req, got, exp);
      end
   endtask

   task automatic rd(logic [7:0] a, output logic [15:0] v);
      addr = a; #1; v = rdata;
   endtask

   task automatic wr(logic [7:0] a, logic [15:0] d);
      @(negedge clk); wr_en = 1; addr = a; wdata = d;
      @(negedge clk); wr_en = 0;
   endtask

   task automatic cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      logic [15:0] v;
      logic [4:0]  e;
      cyc(2); rst_n = 1; cyc(1);
      rd(8'h10, v); chk("R1 latch", v, 16'h1F);
      rd(8'h14, v); chk("R1 col", v, 16'hFF);
      rd(8'h28, v); chk("R1 mask", v, 16'h0);
      rd(8'h20, v); chk("R1 stat", v, 16'h0);
      chk("R1 irq", {15'd0, key_irq}, 16'h0);
      rd(8'h04, v); chk("R2 unmapped", v, 16'h0);

      // R3 R6 R7 sweep: patterns x all column values
      clk_en = 1;
      for (int p = 0; p < 6; p++) begin
         logic [39:0] k = '0;
         for (int b = 0; b < 40; b++) if (((b * 7 + p * 3) % 11) == 0) k[b] = 1'b1;
         keys_in = k; cyc(4);
         for (int col = 0; col < 256; col++) begin
            wr(8'h14, 16'(col));
            e = exp_rows(k, 8'(col));
            rd(8'h10, v); chk("R3 rows", v, {11'd0, e});
            rd(8'h20, v); chk("R6 stat", v, {15'd0, e != 5'h1F});
            chk("R7 irq", {15'd0, key_irq}, {15'd0, e != 5'h1F});
         end
      end
      rd(8'h14, v); chk("R2 col readback", v, 16'hFF);

      // R5 mask width, R6 masked
      keys_in = 40'h1; cyc(4); wr(8'h14, 16'hFF00);
      rd(8'h10, v); chk("R3 col0", v, 16'h1E);
      wr(8'h28, 16'hFFFF);
      rd(8'h28, v); chk("R5 mask", v, 16'h1);
      rd(8'h20, v); chk("R6 masked stat", v, 16'h0);
      chk("R6 masked irq", {15'd0, key_irq}, 16'h0);
      wr(8'h28, 16'hFFFE);
      rd(8'h28, v); chk("R5 mask clr", v, 16'h0);

      // R4 read-only / unmapped writes
      wr(8'h10, 16'h0000); wr(8'h20, 16'hFFFF); wr(8'h30, 16'h00AA); wr(8'h24, 16'h1);
      rd(8'h10, v); chk("R4 latch", v, 16'h1E);
      rd(8'h14, v); chk("R4 col", v, 16'hFF00 & 16'h00FF);
      rd(8'h28, v); chk("R4 mask", v, 16'h0);
      rd(8'h20, v); chk("R4 stat", v, 16'h1);

      // R8 latency with enable high
      keys_in = '0; cyc(4); wr(8'h14, 16'h0000);
      rd(8'h10, v); chk("R8 idle", v, 16'h1F);
      keys_in = 40'h1 << (2*8+3);
      cyc(2); rd(8'h10, v); chk("R8 not yet", v, 16'h1F);
      cyc(1); rd(8'h10, v); chk("R8 third edge", v, 16'h1B);

      // R9 hold with enable low, re-evaluate on write
      clk_en = 0; keys_in = 40'h1; cyc(5);
      rd(8'h10, v); chk("R9 hold", v, 16'h1B);
      chk("R7 irq gated", {15'd0, key_irq}, 16'h0);
      rd(8'h20, v); chk("R6 stat enable low", v, 16'h1);
      wr(8'h28, 16'h0);
      rd(8'h10, v); chk("R9 mask write eval", v, 16'h1E);
      keys_in = 40'h1 << 9; cyc(5);
      rd(8'h10, v); chk("R9 hold2", v, 16'h1E);
      wr(8'h14, 16'h00FD);
      rd(8'h10, v); chk("R9 col write eval", v, 16'h1D);

      // R10 enable rising
      keys_in = 40'h1 << 33; cyc(5);
      rd(8'h10, v); chk("R10 before", v, 16'h1D);
      clk_en = 1; cyc(1);
      rd(8'h10, v); chk("R10 after rise", v, 16'h0F);
      chk("R7 irq on", {15'd0, key_irq}, 16'h1);

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog got=hung exp=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule